// File: doc/BRIEF.md
# Write-Bypass Request Scheduler for a Slow-Write Cache Array

This block sits in front of a last-level cache array whose writes are slow and costly. It keeps pending reads and writes in one shared, age-ordered request queue and sends at most one request per cycle to the array whenever the array signals that it can accept one. A pending read always goes ahead of any pending write, so reads do not wait behind the long write operations.

When the queue is full and writes make up most of it, the scheduler may drop one pending write instead of issuing. It drops the write whose liveness score is lowest, and only if that score is no higher than a threshold. Each write carries an 8-bit liveness score from an external predictor. The threshold is picked once per interval from the average number of pending writes measured over the interval just ended. Heavy write pressure raises the threshold, so dropping becomes more aggressive. A dropped write is reported on a separate notification output, so that a neighbouring block can send its data straight to memory.

Top module: `wbyp_sched`

## Requirements
- R1: After reset, no issue and no bypass is reported, and the request input is ready.
- R2: While any read is pending, an issue slot always goes to the oldest pending read. A write is issued (iss_write=1) only when no read is pending.
- R3: Requests of the same kind are issued in arrival order.
- R4: A request is issued only in a cycle when arr_ready was high. At most one request is issued per cycle.
- R5: A request offered while the queue holds DEPTH entries is refused (in_ready=0) unless an issue or bypass frees an entry in that same cycle. A refused request is never issued later.
- R6: A write is bypassed only when the queue holds DEPTH entries and more than three quarters of DEPTH of them are writes. With DEPTH=16 that means at least 13 writes.
- R7: The bypassed write is the pending write with the lowest score. If several writes share that score, the oldest of them is bypassed.
- R8: A write is bypassed only if its score is less than or equal to the current threshold. Before the first interval ends, the threshold is 51, which is 20% of 255.
- R9: At the end of each interval of INTERVAL cycles, the threshold is reloaded from that interval's average pending-write count A. If A is at most DEPTH/4, the threshold is 51. If A is at most DEPTH/2, it is 127. If A is at most 3*DEPTH/4, it is 178. Otherwise it is 255. The threshold holds between interval ends.
- R10: A cycle that bypasses a write issues nothing to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | New request offered |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | ADDR_W | Request address |
| in_score | input | SCORE_W | Liveness score of a write (ignored for reads) |
| in_ready | output | 1 | Request accepted this cycle when in_valid is high |
| arr_ready | input | 1 | Array can take a request this cycle |
| iss_valid | output | 1 | A request was issued (registered) |
| iss_write | output | 1 | Issued request is a write |
| iss_addr | output | ADDR_W | Issued request address |
| byp_valid | output | 1 | A pending write was dropped (registered) |
| byp_addr | output | ADDR_W | Address of the dropped write |
| byp_score | output | SCORE_W | Score of the dropped write |

## Verification
Several rules are checked by assertions on every cycle. Issues never happen without array readiness, and never in the same cycle as a bypass. Every bypass follows a cycle of full-queue write pressure and respects the threshold then in force. Writes never issue while a read waits, and the chosen write is a true minimum with the oldest-on-tie rule. The threshold changes only at interval boundaries and always holds one of the four table values. Only the scenarios show the behaviours that depend on history. These are the exact issue order of mixed traffic, the loss of a request refused at a full queue, the score-51 versus score-52 boundary under the start-up threshold, and the way a measured average of about half or nearly all of the queue selects 127 or 255 for the next interval.

// File: rtl/wbyp_pkg.sv
package wbyp_pkg;

  // Threshold table percentages, indexed by occupancy band
  localparam int unsigned PCT_BAND0 = 20;
  localparam int unsigned PCT_BAND1 = 50;
  localparam int unsigned PCT_BAND2 = 70;
  localparam int unsigned PCT_BAND3 = 100;

  // Percentage of the full score range, rounded down
  function automatic int unsigned pct_to_score(input int unsigned pct,
                                               input int unsigned score_max);
    return (pct * score_max) / 100;
  endfunction

endpackage

// File: rtl/wbyp_queue.sv
module wbyp_queue #(
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 16,
  parameter int SCORE_W = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic                             push_write,
  input  logic [ADDR_W-1:0]                push_addr,
  input  logic [SCORE_W-1:0]               push_score,
  input  logic                             pop,
  input  logic [IDX_W-1:0]                 pop_idx,
  output logic [DEPTH-1:0]                 ent_vld,
  output logic [DEPTH-1:0]                 ent_wr,
  output logic [DEPTH-1:0][ADDR_W-1:0]     ent_addr,
  output logic [DEPTH-1:0][SCORE_W-1:0]    ent_score,
  output logic [CNT_W-1:0]                 count,
  output logic [CNT_W-1:0]                 wcount
);

  // Compacting storage: index 0 is always the oldest entry
  logic [DEPTH-1:0]              wr_q,    wr_d;
  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q,  addr_d;
  logic [DEPTH-1:0][SCORE_W-1:0] score_q, score_d;
  logic [CNT_W-1:0]              count_q, count_d;
  logic [CNT_W-1:0]              wcount_q, wcount_d;
  logic [CNT_W-1:0]              cnt_after_pop;
  logic                          store_en;

  assign store_en = push | pop;

  always_comb begin
    wr_d          = wr_q;
    addr_d        = addr_q;
    score_d       = score_q;
    cnt_after_pop = count_q - CNT_W'(pop);
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && (IDX_W'(i) >= pop_idx) && (i < DEPTH - 1)) begin
        wr_d[i]    = wr_q[i+1];
        addr_d[i]  = addr_q[i+1];
        score_d[i] = score_q[i+1];
      end
      if (push && (CNT_W'(i) == cnt_after_pop)) begin
        wr_d[i]    = push_write;
        addr_d[i]  = push_addr;
        score_d[i] = push_score;
      end
    end
    count_d  = cnt_after_pop + CNT_W'(push);
    wcount_d = wcount_q + CNT_W'(push & push_write)
                        - CNT_W'(pop & wr_q[pop_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      wcount_q <= '0;
    end else if (store_en) begin
      count_q  <= count_d;
      wcount_q <= wcount_d;
    end
  end

  // Payload registers carry no reset: only entries below count are read
  always_ff @(posedge clk) begin
    if (store_en) begin
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      score_q <= score_d;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_vld[i] = (CNT_W'(i) < count_q);
    end
  end

  assign ent_wr    = wr_q;
  assign ent_addr  = addr_q;
  assign ent_score = score_q;
  assign count     = count_q;
  assign wcount    = wcount_q;

  // R5: no entry is taken beyond capacity
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (count_q == CNT_W'(DEPTH))) |-> pop);

  // R4: removal only from an occupied slot
  a_r4_pop_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CNT_W'(pop_idx) < count_q));

  // R6: the write counter never exceeds the occupancy
  a_r6_wcount_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wcount_q <= count_q);

endmodule

// File: rtl/wbyp_pick.sv
module wbyp_pick #(
  parameter int DEPTH   = 16,
  parameter int SCORE_W = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              ent_vld,
  input  logic [DEPTH-1:0]              ent_wr,
  input  logic [DEPTH-1:0][SCORE_W-1:0] ent_score,
  output logic                          rd_any,
  output logic [IDX_W-1:0]              rd_idx,
  output logic                          wr_any,
  output logic [IDX_W-1:0]              wr_idx,
  output logic [IDX_W-1:0]              min_idx,
  output logic [SCORE_W-1:0]            min_score
);

  // Oldest read and oldest write: first hit scanning from index 0
  always_comb begin
    rd_any = 1'b0;
    rd_idx = '0;
    wr_any = 1'b0;
    wr_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && !ent_wr[i] && !rd_any) begin
        rd_any = 1'b1;
        rd_idx = IDX_W'(i);
      end
      if (ent_vld[i] && ent_wr[i] && !wr_any) begin
        wr_any = 1'b1;
        wr_idx = IDX_W'(i);
      end
    end
  end

  // Lowest-score write; strict compare keeps the oldest on a tie
  always_comb begin
    logic seen;
    seen      = 1'b0;
    min_idx   = '0;
    min_score = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && ent_wr[i] && (!seen || (ent_score[i] < min_score))) begin
        seen      = 1'b1;
        min_idx   = IDX_W'(i);
        min_score = ent_score[i];
      end
    end
  end

  // R7: the chosen write is no worse than any pending write, oldest on tie
  for (genvar g = 0; g < DEPTH; g++) begin : g_min_chk
    a_r7_min_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld[g] && ent_wr[g]) |-> (ent_score[g] >= min_score));
    a_r7_min_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld[g] && ent_wr[g] && (ent_score[g] == min_score))
        |-> (IDX_W'(g) >= min_idx));
  end

  // R7: the chosen slot holds a valid write whenever any write is pending
  a_r7_min_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> (ent_vld[min_idx] && ent_wr[min_idx]));

endmodule

// File: rtl/wbyp_occ_meter.sv
module wbyp_occ_meter
  import wbyp_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int INTERVAL = 10000,
  parameter int SCORE_W  = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int IW      = (INTERVAL > 1) ? $clog2(INTERVAL) : 1,
  localparam int SUM_W   = $clog2(DEPTH * INTERVAL + 1) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   wcount,
  output logic [SCORE_W-1:0] thr
);

  localparam int unsigned SMAX = (1 << SCORE_W) - 1;
  localparam logic [SCORE_W-1:0] THR0 = SCORE_W'(pct_to_score(PCT_BAND0, SMAX));
  localparam logic [SCORE_W-1:0] THR1 = SCORE_W'(pct_to_score(PCT_BAND1, SMAX));
  localparam logic [SCORE_W-1:0] THR2 = SCORE_W'(pct_to_score(PCT_BAND2, SMAX));
  localparam logic [SCORE_W-1:0] THR3 = SCORE_W'(pct_to_score(PCT_BAND3, SMAX));
  // Band limits on 4*sum, so no division by INTERVAL is needed
  localparam logic [SUM_W-1:0] LIM1 = SUM_W'(DEPTH * INTERVAL);
  localparam logic [SUM_W-1:0] LIM2 = SUM_W'(2 * DEPTH * INTERVAL);
  localparam logic [SUM_W-1:0] LIM3 = SUM_W'(3 * DEPTH * INTERVAL);
  localparam logic [IW-1:0]    LAST = IW'(INTERVAL - 1);

  logic [IW-1:0]      tick_q, tick_d;
  logic [SUM_W-1:0]   acc_q, acc_d;
  logic [SUM_W-1:0]   total, total_x4;
  logic [SCORE_W-1:0] thr_q, thr_d;
  logic               at_end;

  always_comb begin
    at_end   = (tick_q == LAST);
    total    = acc_q + SUM_W'(wcount);
    total_x4 = total << 2;
    tick_d   = at_end ? '0 : tick_q + IW'(1);
    acc_d    = at_end ? '0 : total;
    thr_d    = thr_q;
    if (at_end) begin
      if (total_x4 <= LIM1)      thr_d = THR0;
      else if (total_x4 <= LIM2) thr_d = THR1;
      else if (total_x4 <= LIM3) thr_d = THR2;
      else                       thr_d = THR3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else begin
      tick_q <= tick_d;
      acc_q  <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR0;
    end else if (at_end) begin
      thr_q <= thr_d;
    end
  end

  assign thr = thr_q;

  // R9: threshold only moves at an interval boundary
  a_r9_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> $stable(thr_q));

  // R9: threshold is always one of the table values
  a_r9_thr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == THR0) || (thr_q == THR1) || (thr_q == THR2) || (thr_q == THR3));

endmodule

// File: rtl/wbyp_sched.sv
module wbyp_sched #(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 16,
  parameter int SCORE_W  = 8,
  parameter int INTERVAL = 10000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_write,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [SCORE_W-1:0] in_score,
  output logic               in_ready,
  input  logic               arr_ready,
  output logic               iss_valid,
  output logic               iss_write,
  output logic [ADDR_W-1:0]  iss_addr,
  output logic               byp_valid,
  output logic [ADDR_W-1:0]  byp_addr,
  output logic [SCORE_W-1:0] byp_score
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WR_TH    = CNT_W'((3 * DEPTH) / 4);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic [DEPTH-1:0]              ent_vld, ent_wr;
  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr;
  logic [DEPTH-1:0][SCORE_W-1:0] ent_score;
  logic [CNT_W-1:0]              count, wcount;
  logic                          rd_any, wr_any;
  logic [IDX_W-1:0]              rd_idx, wr_idx, min_idx, pop_idx;
  logic [SCORE_W-1:0]            min_score, thr;
  logic                          full, byp_cond, byp_fire, iss_fire, pop, push;

  wbyp_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SCORE_W(SCORE_W)) u_queue (
    .clk        (clk),
    .rst_n      (srst_n),
    .push       (push),
    .push_write (in_write),
    .push_addr  (in_addr),
    .push_score (in_score),
    .pop        (pop),
    .pop_idx    (pop_idx),
    .ent_vld    (ent_vld),
    .ent_wr     (ent_wr),
    .ent_addr   (ent_addr),
    .ent_score  (ent_score),
    .count      (count),
    .wcount     (wcount)
  );

  wbyp_pick #(.DEPTH(DEPTH), .SCORE_W(SCORE_W)) u_pick (
    .clk       (clk),
    .rst_n     (srst_n),
    .ent_vld   (ent_vld),
    .ent_wr    (ent_wr),
    .ent_score (ent_score),
    .rd_any    (rd_any),
    .rd_idx    (rd_idx),
    .wr_any    (wr_any),
    .wr_idx    (wr_idx),
    .min_idx   (min_idx),
    .min_score (min_score)
  );

  wbyp_occ_meter #(.DEPTH(DEPTH), .INTERVAL(INTERVAL), .SCORE_W(SCORE_W)) u_meter (
    .clk    (clk),
    .rst_n  (srst_n),
    .wcount (wcount),
    .thr    (thr)
  );

  // Scheduling decision for this cycle
  always_comb begin
    full     = (count == FULL_CNT);
    byp_cond = full && (wcount > WR_TH);
    byp_fire = byp_cond && wr_any && (min_score <= thr);
    iss_fire = !byp_fire && arr_ready && (count != '0);
    pop      = byp_fire | iss_fire;
    if (byp_fire)    pop_idx = min_idx;
    else if (rd_any) pop_idx = rd_idx;
    else             pop_idx = wr_idx;
    in_ready = !full || pop;
    push     = in_valid && in_ready;
  end

  // Output registers
  logic               iss_valid_q, iss_write_q, byp_valid_q;
  logic [ADDR_W-1:0]  iss_addr_q, iss_addr_d, byp_addr_q, byp_addr_d;
  logic               iss_write_d;
  logic [SCORE_W-1:0] byp_score_q, byp_score_d;

  always_comb begin
    iss_write_d = ent_wr[pop_idx];
    iss_addr_d  = ent_addr[pop_idx];
    byp_addr_d  = ent_addr[pop_idx];
    byp_score_d = ent_score[pop_idx];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      iss_valid_q <= 1'b0;
      byp_valid_q <= 1'b0;
    end else begin
      iss_valid_q <= iss_fire;
      byp_valid_q <= byp_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (iss_fire) begin
      iss_write_q <= iss_write_d;
      iss_addr_q  <= iss_addr_d;
    end
    if (byp_fire) begin
      byp_addr_q  <= byp_addr_d;
      byp_score_q <= byp_score_d;
    end
  end

  assign iss_valid = iss_valid_q;
  assign iss_write = iss_write_q;
  assign iss_addr  = iss_addr_q;
  assign byp_valid = byp_valid_q;
  assign byp_addr  = byp_addr_q;
  assign byp_score = byp_score_q;

  // R4: an issue needs array readiness in the deciding cycle
  a_r4_issue_needs_ready: assert property (@(posedge clk) disable iff (!srst_n)
    iss_valid_q |-> $past(arr_ready));

  // R10: bypass and issue never share a cycle
  a_r10_single_removal: assert property (@(posedge clk) disable iff (!srst_n)
    !(iss_valid_q && byp_valid_q));

  // R6: a bypass follows a full queue dominated by writes
  a_r6_bypass_needs_pressure: assert property (@(posedge clk) disable iff (!srst_n)
    byp_valid_q |-> ($past(count) == FULL_CNT) && ($past(wcount) > WR_TH));

  // R8: bypassed score never exceeds the threshold in force
  a_r8_bypass_under_thr: assert property (@(posedge clk) disable iff (!srst_n)
    byp_valid_q |-> (byp_score_q <= $past(thr)));

  // R2: a write is never issued while a read waits
  a_r2_read_first: assert property (@(posedge clk) disable iff (!srst_n)
    (iss_valid_q && iss_write_q) |-> !$past(rd_any));

endmodule

// File: tb/wbyp_sched_bench.sv
`timescale 1ns/1ps
module wbyp_sched_bench;

  localparam int DEPTH    = 16;
  localparam int ADDR_W   = 16;
  localparam int SCORE_W  = 8;
  localparam int INTERVAL = 128;

  logic               clk;
  logic               rst_n;
  logic               in_valid, in_write, in_ready, arr_ready;
  logic [ADDR_W-1:0]  in_addr;
  logic [SCORE_W-1:0] in_score;
  logic               iss_valid, iss_write, byp_valid;
  logic [ADDR_W-1:0]  iss_addr, byp_addr;
  logic [SCORE_W-1:0] byp_score;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Observation logs, filled just after each rising edge
  logic [ADDR_W-1:0]  iss_log_addr [64];
  logic               iss_log_wr   [64];
  int                 iss_n = 0;
  logic [ADDR_W-1:0]  byp_log_addr [8];
  logic [SCORE_W-1:0] byp_log_score[8];
  int                 byp_n = 0;

  wbyp_sched #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SCORE_W(SCORE_W),
               .INTERVAL(INTERVAL)) u_wbyp_sched (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_write(in_write), .in_addr(in_addr),
    .in_score(in_score), .in_ready(in_ready), .arr_ready(arr_ready),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr),
    .byp_valid(byp_valid), .byp_addr(byp_addr), .byp_score(byp_score)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always begin
    @(posedge clk);
    #1;
    if (iss_valid && iss_n < 64) begin
      iss_log_addr[iss_n] = iss_addr;
      iss_log_wr[iss_n]   = iss_write;
      iss_n++;
    end
    if (byp_valid && byp_n < 8) begin
      byp_log_addr[byp_n]  = byp_addr;
      byp_log_score[byp_n] = byp_score;
      byp_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_write = 1'b0; in_addr = '0;
    in_score = '0; arr_ready = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(2);
    iss_n = 0;
    byp_n = 0;
  endtask

  task automatic push(input logic w, input logic [ADDR_W-1:0] a, input logic [SCORE_W-1:0] s);
    in_valid = 1'b1; in_write = w; in_addr = a; in_score = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R1: idle state after reset
  task automatic t_reset();
    do_reset();
    check(iss_valid == 1'b0, "R1 iss_valid", iss_valid, 0);
    check(byp_valid == 1'b0, "R1 byp_valid", byp_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  // R2 R3 R4: reads overtake writes, order kept within a kind
  task automatic t_order();
    logic [ADDR_W-1:0] exp_a [4];
    logic              exp_w [4];
    exp_a = '{16'h0202, 16'h0204, 16'h0101, 16'h0103};
    exp_w = '{1'b0, 1'b0, 1'b1, 1'b1};
    do_reset();
    push(1'b1, 16'h0101, 8'd90);
    push(1'b0, 16'h0202, 8'd0);
    push(1'b1, 16'h0103, 8'd90);
    push(1'b0, 16'h0204, 8'd0);
    wait_cycles(3);
    check(iss_n == 0, "R4 no issue without arr_ready", iss_n, 0);
    arr_ready = 1'b1;
    wait_cycles(6);
    arr_ready = 1'b0;
    check(iss_n == 4, "R4 issue count", iss_n, 4);
    for (int i = 0; i < 4; i++) begin
      check(iss_log_addr[i] == exp_a[i], "R2 R3 issue order addr", iss_log_addr[i], exp_a[i]);
      check(iss_log_wr[i] == exp_w[i], "R2 issue kind", iss_log_wr[i], exp_w[i]);
    end
    check(byp_n == 0, "R6 no bypass on light load", byp_n, 0);
  endtask

  // R5 R6: full queue with only 12 writes refuses and never bypasses
  task automatic t_full();
    bit seen_refused;
    do_reset();
    for (int i = 0; i < 4; i++)  push(1'b0, 16'h0300 + 16'(i), 8'd0);
    for (int i = 0; i < 12; i++) push(1'b1, 16'h0310 + 16'(i), 8'd10);
    in_valid = 1'b1; in_write = 1'b1; in_addr = 16'h03FF; in_score = 8'd5;
    #0.5;
    check(in_ready == 1'b0, "R5 full queue refuses", in_ready, 0);
    wait_cycles(5);
    in_valid = 1'b0;
    check(byp_n == 0, "R6 twelve writes do not bypass", byp_n, 0);
    arr_ready = 1'b1;
    wait_cycles(22);
    arr_ready = 1'b0;
    check(iss_n == 16, "R5 refused request not stored", iss_n, 16);
    seen_refused = 1'b0;
    for (int i = 0; i < iss_n; i++) if (iss_log_addr[i] == 16'h03FF) seen_refused = 1'b1;
    check(!seen_refused, "R5 refused request never issued", seen_refused, 0);
    check(iss_log_addr[0] == 16'h0300, "R3 oldest read first", iss_log_addr[0], 16'h0300);
    check(iss_log_addr[4] == 16'h0310, "R2 first write after reads", iss_log_addr[4], 16'h0310);
  endtask

  // R8 R10: score 51 equals start-up threshold and is dropped
  task automatic t_edge_at();
    do_reset();
    for (int i = 0; i < 3; i++)  push(1'b0, 16'h0400 + 16'(i), 8'd0);
    for (int i = 0; i < 12; i++) push(1'b1, 16'h0410 + 16'(i), 8'd52);
    push(1'b1, 16'h04AA, 8'd51);
    check(in_ready == 1'b1, "R5 ready while a bypass frees a slot", in_ready, 1);
    arr_ready = 1'b1;
    @(negedge clk);
    check(byp_valid == 1'b1, "R8 score at threshold bypassed", byp_valid, 1);
    check(byp_addr == 16'h04AA, "R7 bypassed address", byp_addr, 16'h04AA);
    check(byp_score == 8'd51, "R8 bypassed score", byp_score, 51);
    check(iss_valid == 1'b0, "R10 no issue in bypass cycle", iss_valid, 0);
    @(negedge clk);
    check(iss_valid == 1'b1 && iss_addr == 16'h0400, "R2 read issued next", iss_addr, 16'h0400);
    arr_ready = 1'b0;
    wait_cycles(3);
    check(byp_n == 1, "R8 single bypass", byp_n, 1);
  endtask

  // R8: score 52 is above start-up threshold and stays queued
  task automatic t_edge_above();
    do_reset();
    for (int i = 0; i < 3; i++)  push(1'b0, 16'h0480 + 16'(i), 8'd0);
    for (int i = 0; i < 13; i++) push(1'b1, 16'h0490 + 16'(i), 8'd52 + 8'(i));
    wait_cycles(10);
    check(byp_n == 0, "R8 score above threshold kept", byp_n, 0);
    check(in_ready == 1'b0, "R5 still full", in_ready, 0);
  endtask

  // R7 R9: half-full write average gives 127; lowest score, oldest on tie
  task automatic t_mid();
    logic [SCORE_W-1:0] sc [8];
    sc = '{8'd150, 8'd120, 8'd140, 8'd120, 8'd200, 8'd160, 8'd130, 8'd180};
    do_reset();
    for (int i = 0; i < 8; i++) push(1'b1, 16'h0500 + 16'(i), sc[i]);
    wait_cycles(180);
    check(byp_n == 0, "R6 no bypass before pressure", byp_n, 0);
    for (int i = 0; i < 5; i++) push(1'b1, 16'h0510 + 16'(i), 8'd130);
    for (int i = 0; i < 3; i++) push(1'b0, 16'h0520 + 16'(i), 8'd0);
    wait_cycles(8);
    check(byp_n == 1, "R9 mid threshold allows one bypass", byp_n, 1);
    check(byp_log_addr[0] == 16'h0501, "R7 oldest lowest-score write", byp_log_addr[0], 16'h0501);
    check(byp_log_score[0] == 8'd120, "R9 score 120 under 127", byp_log_score[0], 120);
  endtask

  // R9: near-full write average gives 255 after the first interval
  task automatic t_high();
    do_reset();
    for (int i = 0; i < 16; i++) push(1'b1, 16'h0600 + 16'(i), 8'd200);
    wait_cycles(60);
    check(byp_n == 0, "R8 start-up threshold blocks score 200", byp_n, 0);
    wait_cycles(120);
    check(byp_n == 1, "R9 high threshold after interval", byp_n, 1);
    check(byp_log_addr[0] == 16'h0600, "R7 tie picks oldest", byp_log_addr[0], 16'h0600);
    check(byp_log_score[0] == 8'd200, "R9 bypassed score", byp_log_score[0], 200);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_write = 1'b0; in_addr = '0;
    in_score = '0; arr_ready = 1'b0;
    t_reset();
    t_order();
    t_full();
    t_edge_at();
    t_edge_above();
    t_mid();
    t_high();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule